// File: doc/BRIEF.md
# Passive Stream Packet Monitor

This block watches a valid/ready/last/data streaming bus and drives none of its wires. Every bus signal enters the block as an input, and no output connects back to the bus, so the monitor cannot disturb the traffic it observes. It counts a beat only in a cycle where the handshake completes. From those accepted beats it builds one summary per packet. A summary holds the number of beats, the data of the first and final beats, and two timestamps read from an internal free-running cycle counter.

Each finished summary is sent to two consumer slots: one for a checker and one for a statistics collector. Each slot keeps its own registered copy and uses a valid/ack pair. A slot never stalls the monitor. If a slot still holds a summary that has not been acknowledged, the new summary is discarded for that slot only, and a sticky drop flag is raised. A running count of completed packets can be read at any time, so a test can confirm at the end that traffic was actually seen.

Top module: `pkt_snoop_mon`

## Requirements
- R1: After synchronous reset, both slot valids and both drop flags are 0, all slot summary fields are 0, and the packet count is 0.
- R2: A beat is counted only in a cycle where bus_valid and bus_ready are both 1. A cycle with valid high and ready low adds nothing to the beat count and never completes a packet.
- R3: A packet ends on the accepted beat that has bus_last at 1. That beat counts toward the packet, and the next accepted beat starts a new packet.
- R4: An accepted beat with bus_last at 1 and no open packet forms a packet with a beat count of 1, whose first and final data are equal.
- R5: The first-data field holds bus_data from the packet's first accepted beat. The final-data field holds bus_data from its last accepted beat.
- R6: The cycle counter reads 0 in the first cycle after reset is released and increases by 1 each cycle. The start stamp is its value on the first accepted beat, and the end stamp is its value on the final accepted beat.
- R7: A slot's valid is 1 from the cycle after the completing beat. Its summary stays unchanged for as long as valid is 1 and ack is 0.
- R8: When ack is 1 while valid is 1 and no new summary arrives, valid is 0 in the next cycle. Acking one slot has no effect on the other slot.
- R9: When a summary completes while a slot holds valid and its ack is 0, that slot keeps its old summary and its drop flag goes to 1 and stays at 1 until reset. The other slot is unaffected.
- R10: When a summary completes in the same cycle that a slot with valid at 1 sees ack at 1, the slot loads the new summary and valid stays 1.
- R11: The packet count increases by exactly 1 for every completed packet, whether or not either slot dropped the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Observed bus valid |
| bus_ready | input | 1 | Observed bus ready |
| bus_last | input | 1 | Observed end-of-packet marker |
| bus_data | input | DATA_W | Observed bus data |
| chk_valid | output | 1 | Checker slot holds a summary |
| chk_ack | input | 1 | Checker slot consumed |
| chk_beats | output | BEAT_W | Checker slot beat count |
| chk_first | output | DATA_W | Checker slot first-beat data |
| chk_final | output | DATA_W | Checker slot final-beat data |
| chk_t_start | output | STAMP_W | Checker slot start stamp |
| chk_t_end | output | STAMP_W | Checker slot end stamp |
| chk_drop | output | 1 | Checker slot sticky drop flag |
| sts_valid | output | 1 | Statistics slot holds a summary |
| sts_ack | input | 1 | Statistics slot consumed |
| sts_beats | output | BEAT_W | Statistics slot beat count |
| sts_first | output | DATA_W | Statistics slot first-beat data |
| sts_final | output | DATA_W | Statistics slot final-beat data |
| sts_t_start | output | STAMP_W | Statistics slot start stamp |
| sts_t_end | output | STAMP_W | Statistics slot end stamp |
| sts_drop | output | 1 | Statistics slot sticky drop flag |
| pkt_count | output | COUNT_W | Completed packet count |

## Verification
The assertions check the slot rules on every cycle:
- a held summary stays stable until ack;
- ack clears valid;
- drop flags are sticky and rise on a blocked publish;
- a one-beat summary has equal first and final data;
- end stamps are never below start stamps;
- the packet count moves only on an accepted beat and only by one per publish.

Only the bench scenarios can show that the field values are correct: the beat count under back-pressure, the exact stamp values, and the data that was captured. They can also show that one slot's ack leaves the other slot alone. The bench covers these with directed sequences and with long random traffic against a cycle model.

// File: rtl/pkt_snoop_pkg.sv
package pkt_snoop_pkg;

   // Packet assembly state: waiting for an opening beat, or inside a packet.
   typedef enum logic {
      SNP_WAIT = 1'b0,
      SNP_OPEN = 1'b1
   } snoop_state_e;

   // Width of one packed summary: {beats, first, final, t_start, t_end}.
   function automatic int unsigned summary_width(int unsigned beat_w,
                                                 int unsigned data_w,
                                                 int unsigned stamp_w);
      return beat_w + 2 * data_w + 2 * stamp_w;
   endfunction

endpackage

// File: rtl/snoop_stamp.sv
module snoop_stamp #(
   parameter int unsigned STAMP_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   output logic [STAMP_W-1:0] stamp
);

   always_ff @(posedge clk) begin
      if (rst) stamp <= '0;
      else     stamp <= stamp + STAMP_W'(1);
   end

endmodule

// File: rtl/snoop_assembler.sv
module snoop_assembler
   import pkt_snoop_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned BEAT_W  = 16,
   parameter int unsigned STAMP_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tap_valid,
   input  logic               tap_ready,
   input  logic               tap_last,
   input  logic [DATA_W-1:0]  tap_data,
   input  logic [STAMP_W-1:0] stamp,
   output logic               done,
   output logic [BEAT_W-1:0]  sum_beats,
   output logic [DATA_W-1:0]  sum_first,
   output logic [DATA_W-1:0]  sum_final,
   output logic [STAMP_W-1:0] sum_t_start,
   output logic [STAMP_W-1:0] sum_t_end
);

   snoop_state_e       state_q;
   logic [BEAT_W-1:0]  beats_q;
   logic [DATA_W-1:0]  first_q;
   logic [STAMP_W-1:0] t_start_q;
   logic               accept;
   logic               opening;

   assign accept  = tap_valid && tap_ready;
   assign opening = (state_q == SNP_WAIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= SNP_WAIT;
         beats_q   <= '0;
         first_q   <= '0;
         t_start_q <= '0;
      end else if (accept) begin
         if (opening) begin
            first_q   <= tap_data;
            t_start_q <= stamp;
            beats_q   <= BEAT_W'(1);
            state_q   <= tap_last ? SNP_WAIT : SNP_OPEN;
         end else begin
            beats_q <= beats_q + BEAT_W'(1);
            if (tap_last) state_q <= SNP_WAIT;
         end
      end
   end

   // The completing beat is folded in combinationally so the summary is
   // registered by the slots on the same edge that accepts the final beat.
   always_comb begin
      done        = accept && tap_last;
      sum_beats   = opening ? BEAT_W'(1) : beats_q + BEAT_W'(1);
      sum_first   = opening ? tap_data : first_q;
      sum_final   = tap_data;
      sum_t_start = opening ? stamp : t_start_q;
      sum_t_end   = stamp;
   end

endmodule

// File: rtl/snoop_slot.sv
module snoop_slot #(
   parameter int unsigned SUM_W = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pub,
   input  logic [SUM_W-1:0] sum_in,
   input  logic             ack,
   output logic             vld,
   output logic [SUM_W-1:0] sum_out,
   output logic             drop
);

   logic room;

   assign room = !vld || ack;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld     <= 1'b0;
         sum_out <= '0;
         drop    <= 1'b0;
      end else if (pub && room) begin
         vld     <= 1'b1;
         sum_out <= sum_in;
      end else if (pub) begin
         drop    <= 1'b1;
      end else if (ack) begin
         vld     <= 1'b0;
      end
   end

endmodule

// File: rtl/pkt_snoop_mon.sv
module pkt_snoop_mon
   import pkt_snoop_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned BEAT_W  = 16,
   parameter int unsigned STAMP_W = 32,
   parameter int unsigned COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_valid,
   input  logic               bus_ready,
   input  logic               bus_last,
   input  logic [DATA_W-1:0]  bus_data,
   output logic               chk_valid,
   input  logic               chk_ack,
   output logic [BEAT_W-1:0]  chk_beats,
   output logic [DATA_W-1:0]  chk_first,
   output logic [DATA_W-1:0]  chk_final,
   output logic [STAMP_W-1:0] chk_t_start,
   output logic [STAMP_W-1:0] chk_t_end,
   output logic               chk_drop,
   output logic               sts_valid,
   input  logic               sts_ack,
   output logic [BEAT_W-1:0]  sts_beats,
   output logic [DATA_W-1:0]  sts_first,
   output logic [DATA_W-1:0]  sts_final,
   output logic [STAMP_W-1:0] sts_t_start,
   output logic [STAMP_W-1:0] sts_t_end,
   output logic               sts_drop,
   output logic [COUNT_W-1:0] pkt_count
);

   localparam int unsigned SUM_W = summary_width(BEAT_W, DATA_W, STAMP_W);
   localparam int unsigned NPORT = 2;   // checker slot, statistics slot

   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_data
      $error("pkt_snoop_mon: DATA_W must be at least 1");
   end
   if (BEAT_W < 2) begin : g_bad_beat
      $error("pkt_snoop_mon: BEAT_W must be at least 2");
   end
   if (STAMP_W < 8) begin : g_bad_stamp
      $error("pkt_snoop_mon: STAMP_W must be at least 8");
   end
   if (COUNT_W < 1) begin : g_bad_count
      $error("pkt_snoop_mon: COUNT_W must be at least 1");
   end

   logic [STAMP_W-1:0]            stamp;
   logic                          pub;
   logic [BEAT_W-1:0]             a_beats;
   logic [DATA_W-1:0]             a_first;
   logic [DATA_W-1:0]             a_final;
   logic [STAMP_W-1:0]            a_t_start;
   logic [STAMP_W-1:0]            a_t_end;
   logic [SUM_W-1:0]              sum_pack;
   logic [NPORT-1:0]              p_ack;
   logic [NPORT-1:0]              p_vld;
   logic [NPORT-1:0]              p_drop;
   logic [NPORT-1:0][SUM_W-1:0]   p_sum;

   snoop_stamp #(
      .STAMP_W (STAMP_W)
   ) u_stamp (
      .clk   (clk),
      .rst   (rst),
      .stamp (stamp)
   );

   snoop_assembler #(
      .DATA_W  (DATA_W),
      .BEAT_W  (BEAT_W),
      .STAMP_W (STAMP_W)
   ) u_asm (
      .clk         (clk),
      .rst         (rst),
      .tap_valid   (bus_valid),
      .tap_ready   (bus_ready),
      .tap_last    (bus_last),
      .tap_data    (bus_data),
      .stamp       (stamp),
      .done        (pub),
      .sum_beats   (a_beats),
      .sum_first   (a_first),
      .sum_final   (a_final),
      .sum_t_start (a_t_start),
      .sum_t_end   (a_t_end)
   );

   assign sum_pack = {a_beats, a_first, a_final, a_t_start, a_t_end};
   assign p_ack    = {sts_ack, chk_ack};

   for (genvar gi = 0; gi < NPORT; gi++) begin : g_slot
      snoop_slot #(
         .SUM_W (SUM_W)
      ) u_slot (
         .clk     (clk),
         .rst     (rst),
         .pub     (pub),
         .sum_in  (sum_pack),
         .ack     (p_ack[gi]),
         .vld     (p_vld[gi]),
         .sum_out (p_sum[gi]),
         .drop    (p_drop[gi])
      );
   end

   assign chk_valid = p_vld[0];
   assign chk_drop  = p_drop[0];
   assign {chk_beats, chk_first, chk_final, chk_t_start, chk_t_end} = p_sum[0];
   assign sts_valid = p_vld[1];
   assign sts_drop  = p_drop[1];
   assign {sts_beats, sts_first, sts_final, sts_t_start, sts_t_end} = p_sum[1];

   always_ff @(posedge clk) begin
      if (rst)      pkt_count <= '0;
      else if (pub) pkt_count <= pkt_count + COUNT_W'(1);
   end

endmodule

// File: rtl/pkt_snoop_mon_chk.sv
module pkt_snoop_mon_chk #(
   parameter int unsigned NPORT   = 2,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned BEAT_W  = 16,
   parameter int unsigned STAMP_W = 32,
   parameter int unsigned COUNT_W = 32,
   parameter int unsigned SUM_W   = 128
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        bus_valid,
   input logic                        bus_ready,
   input logic                        pub,
   input logic [NPORT-1:0]            p_ack,
   input logic [NPORT-1:0]            p_vld,
   input logic [NPORT-1:0]            p_drop,
   input logic [NPORT-1:0][SUM_W-1:0] p_sum,
   input logic [COUNT_W-1:0]          pkt_count
);

   localparam int unsigned T1_LO = 0;
   localparam int unsigned T0_LO = STAMP_W;
   localparam int unsigned FN_LO = 2 * STAMP_W;
   localparam int unsigned FS_LO = FN_LO + DATA_W;
   localparam int unsigned BT_LO = FS_LO + DATA_W;

   AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
      !(bus_valid && bus_ready) |=> $stable(pkt_count)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      pub |=> (pkt_count == $past(pkt_count) + COUNT_W'(1))); // R11

   for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
      AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
         (p_vld[gi] && !p_ack[gi]) |=> (p_vld[gi] && $stable(p_sum[gi]))); // R7

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
         (p_vld[gi] && p_ack[gi] && !pub) |=> !p_vld[gi]); // R8

      AST_DROP_STICKY: assert property (@(posedge clk) disable iff (rst)
         p_drop[gi] |=> p_drop[gi]); // R9

      AST_DROP_RISE: assert property (@(posedge clk) disable iff (rst)
         (p_vld[gi] && !p_ack[gi] && pub) |=> p_drop[gi]); // R9

      AST_REFILL_ON_ACK: assert property (@(posedge clk) disable iff (rst)
         (p_vld[gi] && p_ack[gi] && pub) |=> p_vld[gi]); // R10

      AST_SINGLE_EQUAL: assert property (@(posedge clk) disable iff (rst)
         (p_vld[gi] && p_sum[gi][BT_LO +: BEAT_W] == BEAT_W'(1))
            |-> (p_sum[gi][FS_LO +: DATA_W] == p_sum[gi][FN_LO +: DATA_W])); // R4

      AST_STAMP_ORDER: assert property (@(posedge clk) disable iff (rst)
         p_vld[gi] |-> (p_sum[gi][T1_LO +: STAMP_W] >= p_sum[gi][T0_LO +: STAMP_W])); // R6
   end

endmodule

bind pkt_snoop_mon pkt_snoop_mon_chk #(
   .NPORT   (NPORT),
   .DATA_W  (DATA_W),
   .BEAT_W  (BEAT_W),
   .STAMP_W (STAMP_W),
   .COUNT_W (COUNT_W),
   .SUM_W   (SUM_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_valid (bus_valid),
   .bus_ready (bus_ready),
   .pub       (pub),
   .p_ack     (p_ack),
   .p_vld     (p_vld),
   .p_drop    (p_drop),
   .p_sum     (p_sum),
   .pkt_count (pkt_count)
);

// File: tb/tb_pkt_snoop_mon.sv
`timescale 1ns/1ps
module tb_pkt_snoop_mon;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_valid = 1'b0, bus_ready = 1'b0, bus_last = 1'b0;
   logic [31:0] bus_data = '0;
   logic        chk_ack = 1'b0, sts_ack = 1'b0;
   logic        chk_valid, chk_drop, sts_valid, sts_drop;
   logic [15:0] chk_beats, sts_beats;
   logic [31:0] chk_first, chk_final, chk_t_start, chk_t_end;
   logic [31:0] sts_first, sts_final, sts_t_start, sts_t_end;
   logic [31:0] pkt_count;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   pkt_snoop_mon dut (
      .clk(clk), .rst(rst),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_last(bus_last), .bus_data(bus_data),
      .chk_valid(chk_valid), .chk_ack(chk_ack), .chk_beats(chk_beats), .chk_first(chk_first),
      .chk_final(chk_final), .chk_t_start(chk_t_start), .chk_t_end(chk_t_end), .chk_drop(chk_drop),
      .sts_valid(sts_valid), .sts_ack(sts_ack), .sts_beats(sts_beats), .sts_first(sts_first),
      .sts_final(sts_final), .sts_t_start(sts_t_start), .sts_t_end(sts_t_end), .sts_drop(sts_drop),
      .pkt_count(pkt_count)
   );

   // ---------------- reference model ----------------
   bit          m_open;
   logic [15:0] m_beats;
   logic [31:0] m_first, m_t0, m_stamp, m_count;
   bit          mv[2], mo[2];
   logic [15:0] mb[2];
   logic [31:0] mf[2], ml[2], ms[2], me[2];

   function automatic void model_reset();
      m_open = 0; m_beats = '0; m_first = '0; m_t0 = '0; m_stamp = '0; m_count = '0;
      for (int i = 0; i < 2; i++) begin
         mv[i] = 0; mo[i] = 0; mb[i] = '0; mf[i] = '0; ml[i] = '0; ms[i] = '0; me[i] = '0;
      end
   endfunction

   function automatic void model_edge(bit v, bit r, bit l, logic [31:0] d, bit a0, bit a1);
      bit          acc, done;
      bit          ak[2];
      logic [15:0] nb;
      logic [31:0] nf, nt0;
      acc = v && r;
      done = acc && l;
      ak[0] = a0; ak[1] = a1;
      nb  = m_open ? m_beats + 16'd1 : 16'd1;
      nf  = m_open ? m_first : d;
      nt0 = m_open ? m_t0 : m_stamp;
      for (int i = 0; i < 2; i++) begin
         if (done && (!mv[i] || ak[i])) begin
            mv[i] = 1; mb[i] = nb; mf[i] = nf; ml[i] = d; ms[i] = nt0; me[i] = m_stamp;
         end else if (done) mo[i] = 1;
         else if (ak[i]) mv[i] = 0;
      end
      if (acc) begin
         if (!m_open) begin
            m_first = d; m_t0 = m_stamp; m_beats = 16'd1; m_open = !l;
         end else begin
            m_beats = m_beats + 16'd1;
            if (l) m_open = 0;
         end
      end
      if (done) m_count = m_count + 32'd1;
      m_stamp = m_stamp + 32'd1;
   endfunction

   // ---------------- checking ----------------
   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cmp_port(int i, logic vld, logic [15:0] b, logic [31:0] f, logic [31:0] l,
                           logic [31:0] t0, logic [31:0] t1, logic dr);
      check("R7", $sformatf("slot%0d valid", i), vld, mv[i]);
      check("R9", $sformatf("slot%0d drop", i), dr, mo[i]);
      check("R2", $sformatf("slot%0d beats", i), b, mb[i]);
      check("R5", $sformatf("slot%0d first", i), f, mf[i]);
      check("R5", $sformatf("slot%0d final", i), l, ml[i]);
      check("R6", $sformatf("slot%0d t_start", i), t0, ms[i]);
      check("R6", $sformatf("slot%0d t_end", i), t1, me[i]);
   endtask

   task automatic compare_all();
      cmp_port(0, chk_valid, chk_beats, chk_first, chk_final, chk_t_start, chk_t_end, chk_drop);
      cmp_port(1, sts_valid, sts_beats, sts_first, sts_final, sts_t_start, sts_t_end, sts_drop);
      check("R11", "pkt_count", pkt_count, m_count);
   endtask

   // Drive at a falling edge, advance the model, then compare at the next falling edge.
   task automatic step(bit v, bit r, bit l, logic [31:0] d, bit a0, bit a1);
      bus_valid = v; bus_ready = r; bus_last = l; bus_data = d; chk_ack = a0; sts_ack = a1;
      model_edge(v, r, l, d, a0, a1);
      @(negedge clk);
      compare_all();
   endtask

   initial begin : watchdog
      #(200000 * 20);
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      compare_all();
      check("R1", "reset chk_valid", chk_valid, 0);
      check("R1", "reset sts_valid", sts_valid, 0);
      check("R1", "reset drops", {chk_drop, sts_drop}, 0);
      check("R1", "reset count", pkt_count, 0);

      // R4: one-beat packet at stamp 0
      step(1, 1, 1, 32'hA5A5_0001, 0, 0);
      check("R4", "single beats", chk_beats, 1);
      check("R4", "single first==final", chk_first, chk_final);
      check("R6", "single stamps", {chk_t_start, chk_t_end}, 0);

      // R2/R3: back-pressured two-beat packet, starts at stamp 3, ends at stamp 5
      step(0, 0, 0, 32'h0, 1, 1);
      step(1, 0, 0, 32'h1111_0001, 0, 0);
      step(1, 1, 0, 32'h1111_0001, 0, 0);
      step(1, 0, 1, 32'h2222_0002, 0, 0);
      check("R2", "no publish while ready low", chk_valid, 0);
      step(1, 1, 1, 32'h2222_0002, 0, 0);
      check("R2", "beats under back-pressure", chk_beats, 2);
      check("R3", "final beat included", chk_final, 32'h2222_0002);
      check("R5", "first data", sts_first, 32'h1111_0001);
      check("R6", "start stamp", chk_t_start, 3);
      check("R6", "end stamp", chk_t_end, 5);

      // R8: ack only the checker slot
      step(0, 0, 0, 32'h0, 1, 0);
      check("R8", "acked slot cleared", chk_valid, 0);
      check("R8", "other slot kept", sts_valid, 1);

      // R9: statistics slot full, new packet dropped there only
      step(1, 1, 1, 32'h3333_0003, 0, 0);
      check("R9", "drop flag set", sts_drop, 1);
      check("R9", "old summary kept", sts_first, 32'h1111_0001);
      check("R9", "checker slot loaded", chk_first, 32'h3333_0003);
      check("R9", "checker no drop", chk_drop, 0);
      check("R11", "count after drop", pkt_count, 3);

      // R10: ack and publish in the same cycle
      step(1, 1, 1, 32'h4444_0004, 1, 0);
      check("R10", "valid stays", chk_valid, 1);
      check("R10", "new summary loaded", chk_final, 32'h4444_0004);
      step(0, 0, 0, 32'h0, 1, 1);
      step(0, 0, 0, 32'h0, 0, 0);
      check("R9", "drop sticky after ack", sts_drop, 1);

      // Random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 5) == 0, $urandom,
              ($urandom % 2) == 0, ($urandom % 6) == 0);
      end
      check("R11", "final count nonzero", pkt_count != 0, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule